// File: doc/BRIEF.md
# Voltage/Frequency Transition Sequencer

This block moves a processor core from one operating point to another after software posts a new target, given as a voltage identification (VID) code and a PLL ratio. It changes the VID one code at a time, with a programmable dwell between steps. It asks the PLL to relock to the new ratio, and it holds the core stalled while the relock is under way. The direction of the frequency change sets the order of the two steps. When the frequency rises, the voltage climbs first and the PLL relocks afterwards. When the frequency falls, the PLL relocks first and the voltage comes down afterwards.

Software may post a request at any cycle. A request that arrives during a transition waits in a single pending slot, and a later request replaces it. The waiting request starts once the running transition has finished. A request that names the current operating point finishes at once and changes nothing.

The PLL and the voltage regulator are outside the block. A lock-acknowledge input ends each relock. A stall limit also ends the relock if the acknowledge never arrives, so the core is never stalled for longer than that limit.

Top module: `vf_seq`

## Requirements
- R1: During and straight after reset, `vid_o` equals RST_VID, `ratio_o` equals RST_RATIO, and `relock_o`, `stall_o` and `busy_o` are all 0.
- R2: For a target ratio above the current one, `vid_o` reaches the target VID before `ratio_o` changes. `ratio_o` then takes the target in the cycle after the VID step sequence has ended.
- R3: For a target ratio below the current one, `ratio_o` takes the target in the cycle after the request is taken, while `vid_o` still holds its old value. VID stepping starts only after the relock has ended.
- R4: `vid_o` changes by exactly +1 or -1 per change. Stepping begins when a voltage phase starts. The first change comes dwell_i+1 cycles after that start, and each later change comes dwell_i+1 cycles after the one before.
- R5: `relock_o` is a one-cycle pulse, high in exactly the cycle in which `ratio_o` takes a new value.
- R6: `stall_o` rises together with the relock pulse. It stays high until `pll_lock_i` is sampled high, and it is low in the next cycle.
- R7: If no lock acknowledge arrives, `stall_o` falls after MAX_STALL cycles and the sequence carries on. `stall_o` is never high for more than MAX_STALL consecutive cycles.
- R8: A request made while a transition is running is held and starts in the cycle after that transition ends. Among several such requests, only the last one is carried out.
- R9: A request equal to the current VID and ratio produces no change on `vid_o` or `ratio_o` and no relock pulse. `busy_o` is high for exactly one cycle.
- R10: `busy_o` rises in the cycle after a request is accepted. It stays high until the last VID or ratio change of the final pending request has been made.
- R11: A request with the current ratio but a different VID only steps the VID. It produces no relock pulse and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Software writes a new target this cycle |
| req_vid_i | input | VID_W | Target VID code |
| req_ratio_i | input | RATIO_W | Target PLL ratio |
| dwell_i | input | DWELL_W | Extra cycles between VID steps |
| pll_lock_i | input | 1 | PLL lock acknowledge |
| vid_o | output | VID_W | Current VID code |
| ratio_o | output | RATIO_W | Ratio presented to the PLL |
| relock_o | output | 1 | One-cycle relock request |
| stall_o | output | 1 | Core unavailable |
| busy_o | output | 1 | Transition accepted or in progress |

## Verification
The bench builds the block with MAX_STALL=6, RST_VID=20 and RST_RATIO=10. With this small stall limit, a PLL model that answers late drives the block into the timeout path within a handful of cycles. The bench runs with dwell_i set to 2 and also to 0. Dwell 2 exposes the spacing between VID steps, and dwell 0 exposes back-to-back stepping. Targets both above and below the reset point exercise both step orders, and a burst of requests during a transition exercises the pending slot.

// File: rtl/vf_seq_pkg.sv
package vf_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_VOLT_PRE  = 2'd1,  // voltage before relock (frequency rising)
    ST_RELOCK    = 2'd2,
    ST_VOLT_POST = 2'd3   // voltage after relock or voltage-only change
  } vf_state_e;
endpackage

// File: rtl/vf_pending.sv
module vf_pending #(
  parameter int VID_W   = 6,
  parameter int RATIO_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [VID_W-1:0]   vid_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               take_i,
  output logic               valid_o,
  output logic [VID_W-1:0]   vid_o,
  output logic [RATIO_W-1:0] ratio_o
);
  // newest request always wins the single slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vid_o   <= '0;
      ratio_o <= '0;
    end else if (req_i) begin
      valid_o <= 1'b1;
      vid_o   <= vid_i;
      ratio_o <= ratio_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vf_vid_step.sv
module vf_vid_step #(
  parameter int VID_W   = 6,
  parameter int DWELL_W = 8,
  parameter int RST_VID = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic [VID_W-1:0]   tgt_i,
  output logic [VID_W-1:0]   vid_o,
  output logic               at_tgt_o
);
  logic [DWELL_W-1:0] cnt_q;

  assign at_tgt_o = (vid_o == tgt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_o <= VID_W'(RST_VID);
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= dwell_i;
    end else if (!at_tgt_o) begin
      if (cnt_q == '0) begin
        vid_o <= (tgt_i > vid_o) ? vid_o + 1'b1 : vid_o - 1'b1;
        cnt_q <= dwell_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vf_relock.sv
module vf_relock #(
  parameter int RATIO_W   = 5,
  parameter int MAX_STALL = 2500,
  parameter int RST_RATIO = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               run_i,
  input  logic               lock_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               relock_o,
  output logic               done_o
);
  localparam int STALL_W = $clog2(MAX_STALL + 1);

  logic [STALL_W-1:0] lk_q;

  // lock ack or stall limit ends the relock
  assign done_o = run_i & (lock_i | (lk_q == STALL_W'(MAX_STALL - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_o  <= RATIO_W'(RST_RATIO);
      relock_o <= 1'b0;
      lk_q     <= '0;
    end else begin
      relock_o <= load_i;
      if (load_i) ratio_o <= ratio_i;
      if (!run_i)       lk_q <= '0;
      else if (!done_o) lk_q <= lk_q + 1'b1;
    end
  end
endmodule

// File: rtl/vf_fsm.sv
module vf_fsm
  import vf_seq_pkg::*;
#(
  parameter int VID_W   = 6,
  parameter int RATIO_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pend_valid_i,
  input  logic [VID_W-1:0]   pend_vid_i,
  input  logic [RATIO_W-1:0] pend_ratio_i,
  input  logic [VID_W-1:0]   cur_vid_i,
  input  logic [RATIO_W-1:0] cur_ratio_i,
  input  logic               at_tgt_i,
  input  logic               relock_done_i,
  output logic               take_o,
  output logic [VID_W-1:0]   tgt_vid_o,
  output logic               volt_run_o,
  output logic               relock_run_o,
  output logic               ratio_load_o,
  output logic [RATIO_W-1:0] ratio_val_o,
  output logic               idle_o
);
  vf_state_e          state_q, state_n;
  logic [VID_W-1:0]   tgt_vid_q, tgt_vid_n;
  logic [RATIO_W-1:0] tgt_ratio_q, tgt_ratio_n;

  always_comb begin
    state_n      = state_q;
    tgt_vid_n    = tgt_vid_q;
    tgt_ratio_n  = tgt_ratio_q;
    take_o       = 1'b0;
    ratio_load_o = 1'b0;
    ratio_val_o  = tgt_ratio_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_valid_i) begin
          take_o      = 1'b1;
          tgt_vid_n   = pend_vid_i;
          tgt_ratio_n = pend_ratio_i;
          if (pend_ratio_i > cur_ratio_i) begin
            state_n = ST_VOLT_PRE;
          end else if (pend_ratio_i < cur_ratio_i) begin
            state_n      = ST_RELOCK;
            ratio_load_o = 1'b1;
            ratio_val_o  = pend_ratio_i;
          end else if (pend_vid_i != cur_vid_i) begin
            state_n = ST_VOLT_POST;
          end
        end
      end
      ST_VOLT_PRE: begin
        if (at_tgt_i) begin
          state_n      = ST_RELOCK;
          ratio_load_o = 1'b1;
        end
      end
      ST_RELOCK: begin
        if (relock_done_i) state_n = at_tgt_i ? ST_IDLE : ST_VOLT_POST;
      end
      ST_VOLT_POST: begin
        if (at_tgt_i) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tgt_vid_q   <= '0;
      tgt_ratio_q <= '0;
    end else begin
      state_q     <= state_n;
      tgt_vid_q   <= tgt_vid_n;
      tgt_ratio_q <= tgt_ratio_n;
    end
  end

  assign tgt_vid_o    = tgt_vid_q;
  assign volt_run_o   = (state_q == ST_VOLT_PRE) || (state_q == ST_VOLT_POST);
  assign relock_run_o = (state_q == ST_RELOCK);
  assign idle_o       = (state_q == ST_IDLE);
endmodule

// File: rtl/vf_seq.sv
module vf_seq #(
  parameter int VID_W     = 6,
  parameter int RATIO_W   = 5,
  parameter int DWELL_W   = 8,
  parameter int MAX_STALL = 2500,  // 10 us at 250 MHz
  parameter int RST_VID   = 32,
  parameter int RST_RATIO = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VID_W-1:0]   req_vid_i,
  input  logic [RATIO_W-1:0] req_ratio_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic               pll_lock_i,
  output logic [VID_W-1:0]   vid_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               relock_o,
  output logic               stall_o,
  output logic               busy_o
);
  logic               pend_valid, take, at_tgt, relock_done;
  logic               volt_run, relock_run, ratio_load, idle;
  logic [VID_W-1:0]   pend_vid, tgt_vid;
  logic [RATIO_W-1:0] pend_ratio, ratio_val;

  vf_pending #(.VID_W(VID_W), .RATIO_W(RATIO_W)) u_pending (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_valid_i),
    .vid_i   (req_vid_i),
    .ratio_i (req_ratio_i),
    .take_i  (take),
    .valid_o (pend_valid),
    .vid_o   (pend_vid),
    .ratio_o (pend_ratio)
  );

  vf_fsm #(.VID_W(VID_W), .RATIO_W(RATIO_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pend_valid_i  (pend_valid),
    .pend_vid_i    (pend_vid),
    .pend_ratio_i  (pend_ratio),
    .cur_vid_i     (vid_o),
    .cur_ratio_i   (ratio_o),
    .at_tgt_i      (at_tgt),
    .relock_done_i (relock_done),
    .take_o        (take),
    .tgt_vid_o     (tgt_vid),
    .volt_run_o    (volt_run),
    .relock_run_o  (relock_run),
    .ratio_load_o  (ratio_load),
    .ratio_val_o   (ratio_val),
    .idle_o        (idle)
  );

  vf_vid_step #(.VID_W(VID_W), .DWELL_W(DWELL_W), .RST_VID(RST_VID)) u_vid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (volt_run),
    .dwell_i  (dwell_i),
    .tgt_i    (tgt_vid),
    .vid_o    (vid_o),
    .at_tgt_o (at_tgt)
  );

  vf_relock #(.RATIO_W(RATIO_W), .MAX_STALL(MAX_STALL), .RST_RATIO(RST_RATIO)) u_relock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ratio_load),
    .ratio_i  (ratio_val),
    .run_i    (relock_run),
    .lock_i   (pll_lock_i),
    .ratio_o  (ratio_o),
    .relock_o (relock_o),
    .done_o   (relock_done)
  );

  assign stall_o = relock_run;
  assign busy_o  = pend_valid | ~idle;
endmodule

// File: rtl/vf_seq_chk.sv
module vf_seq_chk #(
  parameter int VID_W     = 6,
  parameter int RATIO_W   = 5,
  parameter int MAX_STALL = 2500
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pll_lock_i,
  input logic [VID_W-1:0]   vid_o,
  input logic [RATIO_W-1:0] ratio_o,
  input logic               relock_o,
  input logic               stall_o,
  input logic               busy_o
);
  int unsigned stall_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stall_run <= 0;
    else if (stall_o) stall_run <= stall_run + 1;
    else              stall_run <= 0;
  end

  assert_vid_unit_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vid_o) |-> (vid_o == $past(vid_o) + 1'b1) || (vid_o == $past(vid_o) - 1'b1));

  assert_ratio_with_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_o) |-> relock_o);

  assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_o |=> !relock_o);

  assert_pulse_stalls_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_o |-> stall_o);

  assert_stall_ends_on_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && pll_lock_i) |=> !stall_o);

  // R2 and R3: the two kinds of change never coincide
  assert_no_joint_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(vid_o) && !$stable(ratio_o)));

  assert_stall_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_run <= MAX_STALL);

  assert_change_while_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(vid_o) || !$stable(ratio_o)) |-> $past(busy_o));

  assert_stall_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> busy_o);
endmodule

bind vf_seq vf_seq_chk #(
  .VID_W(VID_W), .RATIO_W(RATIO_W), .MAX_STALL(MAX_STALL)
) u_vf_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pll_lock_i (pll_lock_i),
  .vid_o      (vid_o),
  .ratio_o    (ratio_o),
  .relock_o   (relock_o),
  .stall_o    (stall_o),
  .busy_o     (busy_o)
);

// File: tb/vf_seq_bench.sv
`timescale 1ns/1ps
module vf_seq_bench;
  localparam int VW = 6, RW = 5, DWW = 8;
  localparam int MAXS = 6, RVID = 20, RRAT = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [VW-1:0] req_vid_i = '0;
  logic [RW-1:0] req_ratio_i = '0;
  logic [DWW-1:0] dwell_i = 8'd2;
  logic pll_lock_i = 1'b0;
  logic [VW-1:0] vid_o;
  logic [RW-1:0] ratio_o;
  logic relock_o, stall_o, busy_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  vf_seq #(.VID_W(VW), .RATIO_W(RW), .DWELL_W(DWW), .MAX_STALL(MAXS),
           .RST_VID(RVID), .RST_RATIO(RRAT)) u_vf_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_vid_i(req_vid_i), .req_ratio_i(req_ratio_i), .dwell_i(dwell_i),
    .pll_lock_i(pll_lock_i), .vid_o(vid_o), .ratio_o(ratio_o),
    .relock_o(relock_o), .stall_o(stall_o), .busy_o(busy_o));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: 0 idle, 1 volt-before, 2 relock, 3 volt-after
  int m_st, m_vid, m_rat, m_cnt, m_lk, m_relock;
  int m_pv, m_pvid, m_prat, m_tvid, m_trat;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_vid = RVID; m_rat = RRAT; m_cnt = 0; m_lk = 0; m_relock = 0;
      m_pv = 0; m_pvid = 0; m_prat = 0; m_tvid = 0; m_trat = 0;
    end else begin
      int ns, nvid, nrat, ncnt, nlk, nrel, ntv, ntr;
      bit take;
      ns = m_st; nvid = m_vid; nrat = m_rat; ncnt = m_cnt; nlk = m_lk;
      nrel = 0; ntv = m_tvid; ntr = m_trat;
      take = (m_st == 0) && (m_pv != 0);
      if (m_st == 0 && take) begin
        ntv = m_pvid; ntr = m_prat;
        if (m_prat > m_rat) ns = 1;
        else if (m_prat < m_rat) begin ns = 2; nrat = m_prat; nrel = 1; end
        else if (m_pvid != m_vid) ns = 3;
      end else if (m_st == 1 || m_st == 3) begin
        if (m_vid == m_tvid) begin
          if (m_st == 1) begin ns = 2; nrat = m_trat; nrel = 1; end
          else ns = 0;
        end else if (m_cnt == 0) begin
          nvid = (m_tvid > m_vid) ? m_vid + 1 : m_vid - 1;
          ncnt = int'(dwell_i);
        end else ncnt = m_cnt - 1;
      end else if (m_st == 2) begin
        if (pll_lock_i || m_lk == MAXS - 1) ns = (m_vid == m_tvid) ? 0 : 3;
        else nlk = m_lk + 1;
      end
      if (!(m_st == 1 || m_st == 3)) ncnt = int'(dwell_i);
      if (m_st != 2) nlk = 0;
      if (req_valid_i) begin
        m_pv = 1; m_pvid = int'(req_vid_i); m_prat = int'(req_ratio_i);
      end else if (take) m_pv = 0;
      m_st = ns; m_vid = nvid; m_rat = nrat; m_cnt = ncnt; m_lk = nlk;
      m_relock = nrel; m_tvid = ntv; m_trat = ntr;
    end
  end

  // monitor and PLL model
  int prev_vid, prev_rat, relock_cnt, stall_len, stall_max, lock_delay = 3, lk_ctr = 0;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_vid = RVID; prev_rat = RRAT;
    end else begin
      chk(int'(vid_o) == m_vid, "R4 vid", int'(vid_o), m_vid);
      chk(int'(ratio_o) == m_rat, "R2 ratio", int'(ratio_o), m_rat);
      chk(int'(relock_o) == m_relock, "R5 relock", int'(relock_o), m_relock);
      chk(int'(stall_o) == int'(m_st == 2), "R6 stall", int'(stall_o), int'(m_st == 2));
      chk(int'(busy_o) == int'(m_pv != 0 || m_st != 0), "R10 busy",
          int'(busy_o), int'(m_pv != 0 || m_st != 0));
      if (int'(ratio_o) < prev_rat) chk(int'(vid_o) == prev_vid, "R3 vid held", int'(vid_o), prev_vid);
      if (int'(ratio_o) > prev_rat) chk(int'(vid_o) == m_tvid, "R2 vid first", int'(vid_o), m_tvid);
      if (relock_o) relock_cnt++;
      if (stall_o) begin stall_len++; if (stall_len > stall_max) stall_max = stall_len; end
      else stall_len = 0;
      prev_vid = int'(vid_o); prev_rat = int'(ratio_o);
      pll_lock_i = 1'b0;
      if (relock_o) lk_ctr = lock_delay;
      if (lk_ctr > 0) begin lk_ctr--; if (lk_ctr == 0) pll_lock_i = 1'b1; end
    end
  end

  task automatic send(input int v, input int r);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vid_i = VW'(v); req_ratio_i = RW'(r);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rc;
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk(vid_o == VW'(RVID) && ratio_o == RW'(RRAT), "R1 reset point", int'(vid_o), RVID);
    chk(!relock_o && !stall_o && !busy_o, "R1 reset flags", int'({relock_o, stall_o, busy_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(vid_o == VW'(RVID) && !busy_o, "R1 after release", int'(vid_o), RVID);

    send(23, 14);  // R2 up
    wait_idle();
    chk(vid_o == 6'd23 && ratio_o == 5'd14, "R2 final", int'(vid_o), 23);

    send(18, 8);   // R3 down
    wait_idle();
    chk(vid_o == 6'd18 && ratio_o == 5'd8, "R3 final", int'(vid_o), 18);

    rc = relock_cnt;
    send(18, 8);   // R9 same point
    wait_idle();
    chk(relock_cnt == rc, "R9 no relock", relock_cnt, rc);
    chk(vid_o == 6'd18 && ratio_o == 5'd8, "R9 unchanged", int'(vid_o), 18);

    send(21, 8);   // R11 voltage only
    wait_idle();
    chk(relock_cnt == rc, "R11 no relock", relock_cnt, rc);
    chk(vid_o == 6'd21, "R11 vid", int'(vid_o), 21);

    send(25, 12);  // R8 deferral, last wins
    repeat (3) @(negedge clk_i);
    send(10, 3);
    send(22, 9);
    wait_idle();
    chk(vid_o == 6'd22 && ratio_o == 5'd9, "R8 last request", int'(ratio_o), 9);

    lock_delay = 50; stall_max = 0;  // R7 timeout
    send(24, 15);
    wait_idle();
    chk(stall_max == MAXS, "R7 stall limit", stall_max, MAXS);
    chk(ratio_o == 5'd15 && vid_o == 6'd24, "R7 proceeds", int'(ratio_o), 15);

    lock_delay = 2; dwell_i = 8'd0;  // R4 back-to-back steps
    send(16, 5);
    wait_idle();
    chk(vid_o == 6'd16 && ratio_o == 5'd5, "R4 dwell zero", int'(vid_o), 16);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule